// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage of a five-stage pipeline (fetch, decode, execute, memory, write-back). It delivers the two source operands, A and B, that decode hands to execute. Each operand names a 4-bit source register. The block compares that name against five destination names still in flight in later stages. If one of them matches, it substitutes the newer value for the stale register-file read.

There are five candidate values:
- the ALU result computed by the instruction now in execute;
- the word being read from data memory by the instruction now in the memory stage;
- the ALU result held in the memory-stage register;
- the load result held in the write-back register;
- the ALU result held in the write-back register.

When several in-flight instructions target the same register, the youngest one wins, since it holds the architecturally newest value. Register name 0xF means "no register". It takes part in no match, whether it appears as a source or as a destination.

The selector is purely combinational and holds no state. Stall insertion for load-use dependences is handled by pipeline control outside this block. Once the consumer has been held back one cycle, the loaded word shows up here as the memory-stage read data.

Top module: `decode_bypass_sel`

## Requirements
- R1: When a source name matches none of the five in-flight destination names, that operand equals its register-file read data.
- R2: Source name 0xF always yields the register-file read data, even when one or more destination names are also 0xF.
- R3: A source matching the execute-stage ALU destination takes the execute-stage ALU output.
- R4: A source matching the memory-stage load destination, and no younger destination, takes the memory read data.
- R5: A source matching the memory-stage ALU destination, and no younger destination, takes the memory-stage ALU result.
- R6: A source matching the write-back load destination, and no younger destination, takes the write-back load result.
- R7: A source matching only the write-back ALU destination takes the write-back ALU result.
- R8: When several destinations match, the priority from highest to lowest is: execute ALU, memory read data, memory ALU, write-back load, write-back ALU.
- R9: Operands A and B are selected independently, so each may take a different source in the same cycle.
- R10: Outputs respond to input changes within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_id | input | 4 | Source register name for operand A (0xF = none) |
| src_b_id | input | 4 | Source register name for operand B (0xF = none) |
| rf_a_data | input | 32 | Register-file read data for operand A |
| rf_b_data | input | 32 | Register-file read data for operand B |
| ex_alu_dst | input | 4 | Destination of the ALU result in execute |
| ex_alu_val | input | 32 | ALU output of the execute stage |
| mem_ld_dst | input | 4 | Load destination of the memory-stage instruction |
| mem_ld_val | input | 32 | Data read from memory this cycle |
| mem_alu_dst | input | 4 | ALU destination held in the memory-stage register |
| mem_alu_val | input | 32 | ALU result held in the memory-stage register |
| wb_ld_dst | input | 4 | Load destination held in the write-back register |
| wb_ld_val | input | 32 | Load result held in the write-back register |
| wb_alu_dst | input | 4 | ALU destination held in the write-back register |
| wb_alu_val | input | 32 | ALU result held in the write-back register |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
Two functions can fall in the same cycle, and both are exercised on purpose.

The first is priority resolution. All five destination names are set to the same register, and the bench then withdraws the youngest destination one cycle at a time, so each step must reveal the next source in order. This judges the ordering rule together with each individual bypass.

The second is the simultaneous selection of A and B from different stages, for example execute for A and write-back for B in the same cycle. Each expected pair is queued when the inputs are driven and compared against both outputs at the following falling edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Bypass sources, listed from youngest (highest priority) to oldest.
  typedef enum int {
    SRC_EX_ALU  = 0,
    SRC_MEM_LD  = 1,
    SRC_MEM_ALU = 2,
    SRC_WB_LD   = 3,
    SRC_WB_ALU  = 4
  } fwd_src_e;

  localparam int NUM_SRC  = 5;
  localparam int NUM_OPND = 2;

endpackage

// File: rtl/fwd_src_bundle.sv
// Gathers the in-flight destination/value pairs into arrays ordered by priority.
module fwd_src_bundle
  import fwd_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]                ex_alu_dst,
  input  logic [DATA_W-1:0]               ex_alu_val,
  input  logic [REG_W-1:0]                mem_ld_dst,
  input  logic [DATA_W-1:0]               mem_ld_val,
  input  logic [REG_W-1:0]                mem_alu_dst,
  input  logic [DATA_W-1:0]               mem_alu_val,
  input  logic [REG_W-1:0]                wb_ld_dst,
  input  logic [DATA_W-1:0]               wb_ld_val,
  input  logic [REG_W-1:0]                wb_alu_dst,
  input  logic [DATA_W-1:0]               wb_alu_val,
  output logic [NUM_SRC-1:0][REG_W-1:0]   dst_ids,
  output logic [NUM_SRC-1:0][DATA_W-1:0]  dst_vals
);

  assign dst_ids[SRC_EX_ALU]   = ex_alu_dst;
  assign dst_vals[SRC_EX_ALU]  = ex_alu_val;
  assign dst_ids[SRC_MEM_LD]   = mem_ld_dst;
  assign dst_vals[SRC_MEM_LD]  = mem_ld_val;
  assign dst_ids[SRC_MEM_ALU]  = mem_alu_dst;
  assign dst_vals[SRC_MEM_ALU] = mem_alu_val;
  assign dst_ids[SRC_WB_LD]    = wb_ld_dst;
  assign dst_vals[SRC_WB_LD]   = wb_ld_val;
  assign dst_ids[SRC_WB_ALU]   = wb_alu_dst;
  assign dst_vals[SRC_WB_ALU]  = wb_alu_val;

endmodule

// File: rtl/fwd_operand_sel.sv
// Selects one operand: the youngest matching in-flight value, else the register file.
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]                src_id,
  input  logic [DATA_W-1:0]               rf_data,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   dst_ids,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  dst_vals,
  output logic [DATA_W-1:0]               opnd
);

  localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

  logic [NUM_SRC-1:0] hit;

  always_comb begin
    logic seen;
    for (int i = 0; i < NUM_SRC; i++) begin
      hit[i] = (src_id != NO_REG) && (dst_ids[i] == src_id);
    end
    // Walk from oldest to youngest so the youngest match is applied last.
    opnd = rf_data;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) opnd = dst_vals[i];
    end

    // R2: the "no register" name never pulls a bypass value.
    if (src_id == NO_REG) begin
      assert_noreg_rf_R2: assert (opnd == rf_data)
        else $error("R2 violated: no-register source did not read register file");
    end
    // R1: with no match the register-file word passes through.
    if (hit == '0) begin
      assert_nohit_rf_R1: assert (opnd == rf_data)
        else $error("R1 violated: unmatched source did not read register file");
    end
    // R3: the execute-stage ALU result beats everything else.
    if ((src_id != NO_REG) && (dst_ids[SRC_EX_ALU] == src_id)) begin
      assert_ex_first_R3: assert (opnd == dst_vals[SRC_EX_ALU])
        else $error("R3 violated: execute ALU match not forwarded");
    end
    // R8: the first match in age order supplies the operand.
    seen = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit[i] && !seen) begin
        assert_youngest_wins_R8: assert (opnd == dst_vals[i])
          else $error("R8 violated: source %0d should have won", i);
      end
      seen = seen | hit[i];
    end
  end

endmodule

// File: rtl/decode_bypass_sel.sv
module decode_bypass_sel
  import fwd_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_a_id,
  input  logic [REG_W-1:0]  src_b_id,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [REG_W-1:0]  ex_alu_dst,
  input  logic [DATA_W-1:0] ex_alu_val,
  input  logic [REG_W-1:0]  mem_ld_dst,
  input  logic [DATA_W-1:0] mem_ld_val,
  input  logic [REG_W-1:0]  mem_alu_dst,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [REG_W-1:0]  wb_ld_dst,
  input  logic [DATA_W-1:0] wb_ld_val,
  input  logic [REG_W-1:0]  wb_alu_dst,
  input  logic [DATA_W-1:0] wb_alu_val,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  logic [NUM_SRC-1:0][REG_W-1:0]   dst_ids;
  logic [NUM_SRC-1:0][DATA_W-1:0]  dst_vals;
  logic [NUM_OPND-1:0][REG_W-1:0]  src_ids;
  logic [NUM_OPND-1:0][DATA_W-1:0] rf_words;
  logic [NUM_OPND-1:0][DATA_W-1:0] opnds;

  fwd_src_bundle #(.REG_W(REG_W), .DATA_W(DATA_W)) bundle_i (
    .ex_alu_dst  (ex_alu_dst),
    .ex_alu_val  (ex_alu_val),
    .mem_ld_dst  (mem_ld_dst),
    .mem_ld_val  (mem_ld_val),
    .mem_alu_dst (mem_alu_dst),
    .mem_alu_val (mem_alu_val),
    .wb_ld_dst   (wb_ld_dst),
    .wb_ld_val   (wb_ld_val),
    .wb_alu_dst  (wb_alu_dst),
    .wb_alu_val  (wb_alu_val),
    .dst_ids     (dst_ids),
    .dst_vals    (dst_vals)
  );

  assign src_ids[0]  = src_a_id;
  assign src_ids[1]  = src_b_id;
  assign rf_words[0] = rf_a_data;
  assign rf_words[1] = rf_b_data;

  // One independent selector per operand (R9).
  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_operand_sel #(.REG_W(REG_W), .DATA_W(DATA_W)) sel_i (
      .src_id   (src_ids[g]),
      .rf_data  (rf_words[g]),
      .dst_ids  (dst_ids),
      .dst_vals (dst_vals),
      .opnd     (opnds[g])
    );
  end

  assign opnd_a = opnds[0];
  assign opnd_b = opnds[1];

endmodule

// File: tb/decode_bypass_sel_tb_top.sv
module decode_bypass_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 2000;

  localparam logic [3:0]  NONE = 4'hF;
  localparam logic [31:0] RFA  = 32'hA0A0_0001;
  localparam logic [31:0] RFB  = 32'hB0B0_0002;
  localparam logic [31:0] EXV  = 32'h1111_0001;
  localparam logic [31:0] MLD  = 32'h2222_0002;
  localparam logic [31:0] MAL  = 32'h3333_0003;
  localparam logic [31:0] WLD  = 32'h4444_0004;
  localparam logic [31:0] WAL  = 32'h5555_0005;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  src_a_id = 4'h2, src_b_id = 4'h5;
  logic [31:0] rf_a_data = RFA, rf_b_data = RFB;
  logic [3:0]  ex_alu_dst = NONE, mem_ld_dst = NONE, mem_alu_dst = NONE;
  logic [3:0]  wb_ld_dst = NONE, wb_alu_dst = NONE;
  logic [31:0] ex_alu_val = EXV, mem_ld_val = MLD, mem_alu_val = MAL;
  logic [31:0] wb_ld_val = WLD, wb_alu_val = WAL;
  logic [31:0] opnd_a, opnd_b;

  decode_bypass_sel dut_i (
    .src_a_id(src_a_id), .src_b_id(src_b_id),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .ex_alu_dst(ex_alu_dst), .ex_alu_val(ex_alu_val),
    .mem_ld_dst(mem_ld_dst), .mem_ld_val(mem_ld_val),
    .mem_alu_dst(mem_alu_dst), .mem_alu_val(mem_alu_val),
    .wb_ld_dst(wb_ld_dst), .wb_ld_val(wb_ld_val),
    .wb_alu_dst(wb_alu_dst), .wb_alu_val(wb_alu_val),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  task automatic check_val(string tag, string which, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s operand %s: actual=%h expected=%h", tag, which, act, exp);
    end
  endtask

  // Driver: apply a vector right after a rising edge and queue its expectation.
  task automatic push(logic [31:0] ea, logic [31:0] eb, string tag);
    exp_t e;
    e.a = ea; e.b = eb; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle_dsts();
    ex_alu_dst = NONE; mem_ld_dst = NONE; mem_alu_dst = NONE;
    wb_ld_dst = NONE; wb_alu_dst = NONE;
  endtask

  // Monitor: compare at the falling edge, away from where inputs change.
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check_val(e.tag, "A", opnd_a, e.a);
      check_val(e.tag, "B", opnd_b, e.b);
    end
  end

  initial begin
    // Idle state: nothing in flight, register file passes through (R1).
    @(posedge clk); push(RFA, RFB, "R1 idle");

    // R1: destinations present but none equal to either source.
    @(posedge clk);
    src_a_id = 4'h2; src_b_id = 4'h5;
    ex_alu_dst = 4'h1; mem_ld_dst = 4'h3; mem_alu_dst = 4'h4;
    wb_ld_dst = 4'h6; wb_alu_dst = 4'h7;
    push(RFA, RFB, "R1 nomatch");

    // R2: source 0xF with every destination also 0xF.
    @(posedge clk);
    idle_dsts(); src_a_id = NONE; src_b_id = NONE;
    push(RFA, RFB, "R2 noreg");

    // R3: execute ALU bypass on A.
    @(posedge clk);
    idle_dsts(); src_a_id = 4'h3; src_b_id = 4'h8; ex_alu_dst = 4'h3;
    push(EXV, RFB, "R3 ex");

    // R4: memory read data on A.
    @(posedge clk);
    idle_dsts(); src_a_id = 4'h4; mem_ld_dst = 4'h4;
    push(MLD, RFB, "R4 memld");

    // R5: memory ALU result on B.
    @(posedge clk);
    idle_dsts(); src_a_id = 4'h1; src_b_id = 4'h5; mem_alu_dst = 4'h5;
    push(RFA, MAL, "R5 memalu");

    // R6: write-back load result on A.
    @(posedge clk);
    idle_dsts(); src_a_id = 4'h6; src_b_id = 4'h0; wb_ld_dst = 4'h6;
    push(WLD, RFB, "R6 wbld");

    // R7: write-back ALU result on B.
    @(posedge clk);
    idle_dsts(); src_a_id = 4'h0; src_b_id = 4'h7; wb_alu_dst = 4'h7;
    push(RFA, WAL, "R7 wbalu");

    // R8: all five target r9; withdraw the youngest one step at a time.
    @(posedge clk);
    src_a_id = 4'h9; src_b_id = 4'h9;
    ex_alu_dst = 4'h9; mem_ld_dst = 4'h9; mem_alu_dst = 4'h9;
    wb_ld_dst = 4'h9; wb_alu_dst = 4'h9;
    push(EXV, EXV, "R8 all");
    @(posedge clk); ex_alu_dst = NONE;  push(MLD, MLD, "R8 no-ex");
    @(posedge clk); mem_ld_dst = NONE;  push(MAL, MAL, "R8 no-memld");
    @(posedge clk); mem_alu_dst = NONE; push(WLD, WLD, "R8 no-memalu");
    @(posedge clk); wb_ld_dst = NONE;   push(WAL, WAL, "R8 no-wbld");

    // R9: A from execute, B from write-back ALU, same cycle.
    @(posedge clk);
    idle_dsts(); src_a_id = 4'h3; src_b_id = 4'h7;
    ex_alu_dst = 4'h3; wb_alu_dst = 4'h7;
    push(EXV, WAL, "R9 split");

    // R9: A from memory read data, B from memory ALU result.
    @(posedge clk);
    idle_dsts(); src_a_id = 4'hA; src_b_id = 4'hB;
    mem_ld_dst = 4'hA; mem_alu_dst = 4'hB;
    push(MLD, MAL, "R9 memsplit");

    // R2: source 0xF while a destination is 0xF and B still forwards.
    @(posedge clk);
    idle_dsts(); src_a_id = NONE; src_b_id = 4'hC;
    ex_alu_dst = NONE; wb_ld_dst = 4'hC;
    push(RFA, WLD, "R2 mixed");

    // R10: change inputs between edges and observe without any clock edge.
    @(negedge clk);
    #1;
    idle_dsts(); src_a_id = 4'hD; src_b_id = 4'hE; ex_alu_dst = 4'hD;
    #1;
    check_val("R10 comb", "A", opnd_a, EXV);
    check_val("R10 comb", "B", opnd_b, RFB);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule